// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. It chooses which analog channel feeds the external sample-and-hold and opens the sampling window. It then walks a trial code from the most significant bit down to the least significant bit. At each step it presents the trial code to an external resistor-string tap and reads back a one-bit comparator decision. When the last bit is decided, the finished code goes into a result register and a one-cycle end-of-conversion pulse is raised.

Conversions run back to back while the run input is high. Dropping run, or asserting standby, stops the sequence at once.

A separate enable input starts a warm-up counter. A run that begins before that counter has finished still converts. The first result of such a run is marked as suspect, so software can throw it away.

Top module: `sar_adc_seq`

## Requirements
- R1: On the first cycle after sampling ends, `tap_code` equals 1 << (NBITS-1), which is 512 for 10 bits. While no comparison is in progress, `tap_code` is 0.
- R2: Each bit is decided on the last of its CMP_CYC cycles. The bit stays 1 when `cmp_hi` is 1, meaning the input is not below the tap, and is cleared otherwise. The next lower bit is then set tentatively. So after bit NBITS-1, the tap becomes 768 (bit 9 kept) or 256 (bit 9 cleared), and the final result equals the held input code.
- R3: Every conversion begins with `sample_en` high for exactly SAMP_CYC cycles. After that the input is held, so later changes to the analog input do not alter the result of that conversion.
- R4: `result` changes only on the edge that also raises `eoc_irq`. `eoc_irq` is high for a single cycle. While run stays high, consecutive pulses are SAMP_CYC + NBITS*CMP_CYC cycles apart.
- R5: Conversions repeat while `run` is high. Dropping `run` aborts the conversion: `busy` falls on the next cycle, no pulse is raised and `result` keeps its old value.
- R6: If a run starts while `enable` is low, or before WARM_CYC cycles of continuous enable have elapsed, the first result of that run carries `result_suspect` = 1. Later results carry 0. A run restarted with the warm-up already complete carries 0. Dropping `enable` restarts the warm-up.
- R7: `chan_out` is loaded from `chan_sel` only when a sampling phase begins. A change of `chan_sel` during a comparison first affects the following conversion.
- R8: Asserting `standby` aborts the conversion in the same way as dropping `run`. Conversion resumes, with a fresh sampling phase, once `standby` is released.
- R9: `busy` is high from the first sampling cycle until the result is latched, and throughout a continuous run. After reset, `busy`, `sample_en`, `eoc_irq`, `result` and `tap_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; starts the warm-up count |
| run | input | 1 | Run request; converts continuously while high |
| standby | input | 1 | Stops all conversion activity |
| chan_sel | input | CH_W | Requested analog channel |
| cmp_hi | input | 1 | Comparator: 1 when the held input is not below the tap |
| chan_out | output | CH_W | Channel applied to the analog mux |
| sample_en | output | 1 | Sample-and-hold tracking window |
| tap_code | output | NBITS | Trial code driving the resistor-string tap |
| result | output | NBITS | Last completed conversion |
| result_suspect | output | 1 | Marks `result` as the first of a run started before warm-up |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |
| busy | output | 1 | Sampling or comparing |

## Verification
The bench builds the block with NBITS=10, CH_W=2, WARM_CYC=8, SAMP_CYC=2 and CMP_CYC=1. With these values a full conversion takes 12 cycles, so every one of the 1024 input codes can be converted in one continuous run. The short warm-up lets both a premature start and a warmed restart occur within a few conversions. Changing the analog input right after the hold point in every conversion exercises the hold behaviour across the whole code range. A second channel with a distinct level shows exactly which conversion picks up a new channel selection.

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int NBITS    = 10,
  parameter int CH_W     = 3,
  parameter int WARM_CYC = 700,
  parameter int SAMP_CYC = 8,
  parameter int CMP_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic             standby,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             cmp_hi,
  output logic [CH_W-1:0]  chan_out,
  output logic             sample_en,
  output logic [NBITS-1:0] tap_code,
  output logic [NBITS-1:0] result,
  output logic             result_suspect,
  output logic             eoc_irq,
  output logic             busy
);
  localparam int MAXC   = (SAMP_CYC > CMP_CYC) ? SAMP_CYC : CMP_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int IDX_W  = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int WARM_W = $clog2(WARM_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [NBITS-1:0] sar;
  logic [NBITS-1:0] decided;
  logic [WARM_W-1:0] warm;
  logic             first_bad;

  wire go        = run && !standby;
  wire ready     = enable && (warm == WARM_W'(WARM_CYC));
  wire samp_done = (st == S_SAMP) && (cnt == CNT_W'(SAMP_CYC - 1));
  wire step      = (st == S_CONV) && (cnt == CNT_W'(CMP_CYC - 1));

  always_comb begin
    decided      = sar;
    decided[idx] = cmp_hi;
  end

  wire [NBITS-1:0] trial_next =
    decided | ((idx == '0) ? '0 : (NBITS'(1) << (idx - 1'b1)));

  assign sample_en = (st == S_SAMP);
  assign busy      = (st != S_IDLE);
  assign tap_code  = (st == S_CONV) ? sar : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) warm <= '0;
    else if (!ready)       warm <= warm + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      cnt            <= '0;
      idx            <= '0;
      sar            <= '0;
      chan_out       <= '0;
      result         <= '0;
      result_suspect <= 1'b0;
      eoc_irq        <= 1'b0;
      first_bad      <= 1'b0;
    end else begin
      eoc_irq <= 1'b0;
      if (!go) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            st        <= S_SAMP;
            cnt       <= '0;
            chan_out  <= chan_sel;
            first_bad <= !ready;
          end
          S_SAMP: begin
            if (samp_done) begin
              st  <= S_CONV;
              cnt <= '0;
              idx <= IDX_W'(NBITS - 1);
              sar <= NBITS'(1) << (NBITS - 1);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_CONV: begin
            if (!step) begin
              cnt <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              if (idx != '0) begin
                sar <= trial_next;
                idx <= idx - 1'b1;
              end else begin
                result         <= decided;
                result_suspect <= first_bad;
                first_bad      <= 1'b0;
                eoc_irq        <= 1'b1;
                st             <= S_SAMP;
                chan_out       <= chan_sel;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int NBITS = 10,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             standby,
  input logic [CH_W-1:0]  chan_out,
  input logic             sample_en,
  input logic [NBITS-1:0] tap_code,
  input logic [NBITS-1:0] result,
  input logic             eoc_irq,
  input logic             busy
);
  p_tap_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $fell(sample_en) |-> tap_code == (NBITS'(1) << (NBITS - 1)));

  p_eoc_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_irq |-> $stable(result));

  p_abort_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !busy && !eoc_irq);

  p_chan_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sample_en |-> $stable(chan_out));

  p_standby_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !busy && !eoc_irq);

  p_eoc_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> busy);
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.NBITS(NBITS), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .standby(standby),
  .chan_out(chan_out), .sample_en(sample_en), .tap_code(tap_code),
  .result(result), .eoc_irq(eoc_irq), .busy(busy)
);

// File: tb/sim_sar_adc_seq.sv
`timescale 1ns/1ps
module sim_sar_adc_seq;
  localparam int NB = 10, CW = 2, WARM = 8, SAMP = 2, CMPC = 1;
  localparam int PERIOD = SAMP + NB * CMPC;
  localparam int FULL = 1 << NB;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, run = 1'b0, standby = 1'b0;
  logic [CW-1:0] chan_sel = '0;
  logic cmp_hi;
  logic [CW-1:0] chan_out;
  logic sample_en, result_suspect, eoc_irq, busy;
  logic [NB-1:0] tap_code, result, held;
  logic [NB-1:0] analog [4];
  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (sample_en) held <= analog[chan_out];
  assign cmp_hi = (held >= tap_code);

  sar_adc_seq #(.NBITS(NB), .CH_W(CW), .WARM_CYC(WARM), .SAMP_CYC(SAMP), .CMP_CYC(CMPC)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .standby(standby),
    .chan_sel(chan_sel), .cmp_hi(cmp_hi), .chan_out(chan_out), .sample_en(sample_en),
    .tap_code(tap_code), .result(result), .result_suspect(result_suspect),
    .eoc_irq(eoc_irq), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_eoc(input string req);
    int t = 0;
    do begin @(negedge clk); t++; end while (!eoc_irq && t < 2000);
    if (!eoc_irq) chk(1'b0, {req, " timeout"}, 0, 1);
  endtask

  task automatic wait_conv;
    @(negedge clk);
    while (sample_en) @(negedge clk);
  endtask

  task automatic quiet(input string req, input int n, input logic [NB-1:0] keep);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!eoc_irq && !busy, {req, " no pulse/busy"}, eoc_irq, 0);
    end
    chk(result == keep, {req, " result kept"}, result, keep);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int last, s, nv;
    logic [NB-1:0] keep;
    for (int i = 0; i < 4; i++) analog[i] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !sample_en && !eoc_irq, "R9 reset flags", busy, 0);
    chk(result == 0 && tap_code == 0, "R9 reset data", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && result == 0, "R9 idle after reset", busy, 0);

    enable = 1'b1;
    repeat (WARM + 2) @(negedge clk);
    run = 1'b1;
    last = 0;
    for (int v = 0; v < FULL; v++) begin
      wait_eoc("R2");
      chk(result == NB'(v), "R2 result", result, v);
      chk(!result_suspect, "R6 warmed start", result_suspect, 0);
      chk(busy, "R9 busy at eoc", busy, 1);
      if (v > 0) chk(cyc - last == PERIOD, "R4 period", cyc - last, PERIOD);
      last = cyc;
      nv = (v + 1) % FULL;
      analog[0] = NB'(nv);
      s = 0;
      while (sample_en) begin s++; @(negedge clk); end
      chk(s == SAMP, "R3 sample length", s, SAMP);
      chk(tap_code == NB'(512), "R1 first tap", tap_code, 512);
      analog[0] = NB'(FULL - 1 - nv);
      @(negedge clk);
      chk(tap_code == NB'(nv >= 512 ? 768 : 256), "R2 second tap", tap_code, nv >= 512 ? 768 : 256);
    end

    // R7 channel switch
    analog[0] = 10'h2AA; analog[1] = 10'h155;
    wait_eoc("R7");
    wait_conv();
    chan_sel = 2'd1;
    wait_eoc("R7");
    chk(result == 10'h2AA, "R7 old channel result", result, 'h2AA);
    @(negedge clk);
    chk(chan_out == 2'd1, "R7 new channel applied", chan_out, 1);
    wait_eoc("R7");
    chk(result == 10'h155, "R7 new channel result", result, 'h155);

    // R5 abort by run
    wait_conv();
    repeat (3) @(negedge clk);
    keep = result;
    run = 1'b0;
    quiet("R5", 30, keep);
    run = 1'b1;
    wait_eoc("R6");
    chk(!result_suspect, "R6 warmed restart", result_suspect, 0);
    chk(result == 10'h155, "R5 restart result", result, 'h155);

    // R8 standby
    wait_conv();
    repeat (2) @(negedge clk);
    keep = result;
    standby = 1'b1;
    quiet("R8", 30, keep);
    standby = 1'b0;
    @(negedge clk);
    chk(sample_en, "R8 resume sampling", sample_en, 1);
    wait_eoc("R8");
    chk(result == 10'h155, "R8 resume result", result, 'h155);

    // R6 premature start
    run = 1'b0; enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1; run = 1'b1;
    wait_eoc("R6");
    chk(result_suspect, "R6 early start flagged", result_suspect, 1);
    wait_eoc("R6");
    chk(!result_suspect, "R6 second result clean", result_suspect, 0);
    run = 1'b0; enable = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    wait_eoc("R6");
    chk(result_suspect, "R6 run without enable flagged", result_suspect, 1);
    chk(result == 10'h155, "R6 converts without enable", result, 'h155);
    wait_eoc("R6");
    chk(!result_suspect, "R6 later clean", result_suspect, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule